// File: doc/BRIEF.md
# Baud Tick Generator with Clock Select

This block turns a reference clock enable into the bit-rate strobe that a UART uses to time its bits. Everything runs on one system clock. Each clock source arrives as a one-cycle enable: one from the crystal and one from an alternate source. A single 32-bit baud control register sets three things: which source counts, how that source is pre-divided (by 3, by 2 or not at all), and which divisor the final reload counter uses.

The pre-divider does not make a derived clock. It gives a one-cycle enable after every N source enables. A reload counter then counts those enables and emits `bit_tick` once every (divisor + 1) of them. Whenever the register is written, both stages restart from the new settings. The first tick after a write therefore already follows the new period.

Register fields:
- Bits 22:0 hold the divisor.
- Bit 23 chooses the register divisor (1) or a fixed default divisor (0).
- Bit 24 chooses the crystal enable (1) or the alternate enable (0).
- Bit 26 = 1 turns pre-division off.
- Bit 27 = 1 selects divide by 2.
- With bits 26 and 27 both 0, the pre-divider divides by 3.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset the register holds bit 23 = 1, bit 24 = 1, bit 26 = 0, bit 27 = 0 and divisor RST_DIV (default 4). The tick is low in the first cycle after reset, and the first tick comes 3*(RST_DIV+1)+1 clock edges after the last reset edge (16 by default).
- R2: When bit 23 = 1 and the selected source enable is high every cycle, ticks repeat every P*(D+1) clock cycles. Here D is bits 22:0 and P is the pre-divide ratio.
- R3: The pre-divide ratio P is 2 when bit 27 = 1. It is 1 when bit 27 = 0 and bit 26 = 1. It is 3 when both bits are 0.
- R4: When bits 26 and 27 are both 1, divide by 2 wins (P = 2).
- R5: When bit 23 = 0, the counter uses the fixed divisor FIX_DIV (default 7), and bits 22:0 have no effect.
- R6: Bit 24 = 1 counts `xtal_en` and bit 24 = 0 counts `alt_en`. While the selected enable stays low, no tick is produced. A source that is enabled every other cycle doubles the period.
- R7: A write restarts both stages. The tick is low in the cycle after the write edge, and the first tick comes P*(D+1)+1 edges after the write edge, whatever count was in progress.
- R8: When the period is longer than one cycle, the tick is exactly one cycle wide.
- R9: Divisor 0 gives the fastest rate: one tick per cycle with no pre-division, and one tick every 3 cycles with divide by 3.
- R10: Bits 25 and 31:28 have no effect on the tick timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| xtal_en | input | 1 | One-cycle enable from the crystal source |
| alt_en | input | 1 | One-cycle enable from the alternate source |
| cfg_we | input | 1 | Write strobe for the baud control register |
| cfg_wdata | input | 32 | Value written to the baud control register |
| bit_tick | output | 1 | Registered one-cycle bit-rate tick |

## Verification
The hardest case to reach from the ports is a write that lands partway through a long count. Once the register has been rewritten, the old count is hidden. The bench starts a slow setting and lets it run for a few cycles. It then writes a fast setting and checks two things: that the first tick arrives exactly P*(D+1)+1 edges later, and that no leftover tick from the old period appears. A separate case makes the source enable gapped by toggling the alternate enable every cycle. This shows that the counter advances only on qualified enables and not on clock cycles.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int CFG_W      = 32;
  localparam int DIV_W      = 23;
  localparam int B_USE_FLD  = 23;
  localparam int B_USE_XTAL = 24;
  localparam int B_NO_PDIV  = 26;
  localparam int B_PDIV2    = 27;

  typedef enum logic [1:0] {
    PD_DIV3 = 2'd0,
    PD_DIV2 = 2'd1,
    PD_NONE = 2'd2
  } prediv_e;

  // divide by 2 outranks no pre-division
  function automatic prediv_e pick_prediv(input logic [CFG_W-1:0] c);
    if (c[B_PDIV2])        return PD_DIV2;
    else if (c[B_NO_PDIV]) return PD_NONE;
    else                   return PD_DIV3;
  endfunction
endpackage

// File: rtl/baud_src_sel.sv
module baud_src_sel (
  input  logic use_xtal,
  input  logic xtal_en,
  input  logic alt_en,
  output logic src_en
);
  always_comb src_en = use_xtal ? xtal_en : alt_en;
endmodule

// File: rtl/baud_prediv.sv
module baud_prediv
  import baud_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    restart,
  input  prediv_e mode,
  input  logic    src_en,
  output logic    pre_en
);
  logic [1:0] phase;
  logic [1:0] last;

  always_comb begin
    unique case (mode)
      PD_DIV2: last = 2'd1;
      PD_NONE: last = 2'd0;
      default: last = 2'd2;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      phase  <= '0;
      pre_en <= 1'b0;
    end else if (src_en) begin
      pre_en <= (phase >= last);
      phase  <= (phase >= last) ? 2'd0 : phase + 2'd1;
    end else begin
      pre_en <= 1'b0;
    end
  end

  // R6
  always @(posedge clk)
    if (!rst) pre_from_src_chk: assert property (disable iff (rst) pre_en |-> $past(src_en));

  // R3
  always @(posedge clk)
    if (!rst) phase_bound_chk: assert property (disable iff (rst) phase <= 2'd2);
endmodule

// File: rtl/baud_reload_cnt.sv
module baud_reload_cnt #(
  parameter int DIV_W = 23
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] rst_div,
  input  logic             restart,
  input  logic [DIV_W-1:0] restart_div,
  input  logic [DIV_W-1:0] run_div,
  input  logic             step,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= rst_div;
      tick <= 1'b0;
    end else if (restart) begin
      cnt  <= restart_div;
      tick <= 1'b0;
    end else if (step) begin
      if (cnt == '0) begin
        cnt  <= run_div;
        tick <= 1'b1;
      end else begin
        cnt  <= cnt - 1'b1;
        tick <= 1'b0;
      end
    end else begin
      tick <= 1'b0;
    end
  end

  // R8
  property tick_needs_step_p;
    @(posedge clk) disable iff (rst) tick |-> $past(step);
  endproperty
  tick_from_step_chk: assert property (tick_needs_step_p);

  // R2
  property cnt_in_range_p;
    @(posedge clk) disable iff (rst) !$past(rst) |-> cnt <= run_div;
  endproperty
  cnt_range_chk: assert property (cnt_in_range_p);
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_pkg::*;
#(
  parameter int RST_DIV = 4,
  parameter int FIX_DIV = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             xtal_en,
  input  logic             alt_en,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic             bit_tick
);
  localparam logic [DIV_W-1:0] RST_DIV_V = DIV_W'(RST_DIV);
  localparam logic [DIV_W-1:0] FIX_DIV_V = DIV_W'(FIX_DIV);
  localparam logic [CFG_W-1:0] CFG_RST   =
      (CFG_W'(1) << B_USE_FLD) | (CFG_W'(1) << B_USE_XTAL) | CFG_W'(RST_DIV_V);

  logic [CFG_W-1:0] cfg_q;
  logic             src_en;
  logic             pre_en;
  prediv_e          mode;
  logic [DIV_W-1:0] run_div;
  logic [DIV_W-1:0] new_div;

  always_ff @(posedge clk) begin
    if (rst)         cfg_q <= CFG_RST;
    else if (cfg_we) cfg_q <= cfg_wdata;
  end

  // a write takes effect in the same edge: the restart loads from wdata
  always_comb begin
    mode    = cfg_we ? pick_prediv(cfg_wdata) : pick_prediv(cfg_q);
    run_div = cfg_q[B_USE_FLD] ? cfg_q[DIV_W-1:0] : FIX_DIV_V;
    new_div = cfg_wdata[B_USE_FLD] ? cfg_wdata[DIV_W-1:0] : FIX_DIV_V;
  end

  baud_src_sel u_sel (
    .use_xtal (cfg_q[B_USE_XTAL]),
    .xtal_en  (xtal_en),
    .alt_en   (alt_en),
    .src_en   (src_en)
  );

  baud_prediv u_pdiv (
    .clk     (clk),
    .rst     (rst),
    .restart (cfg_we),
    .mode    (mode),
    .src_en  (src_en),
    .pre_en  (pre_en)
  );

  baud_reload_cnt #(.DIV_W(DIV_W)) u_cnt (
    .clk         (clk),
    .rst         (rst),
    .rst_div     (RST_DIV_V),
    .restart     (cfg_we),
    .restart_div (new_div),
    .run_div     (run_div),
    .step        (pre_en),
    .tick        (bit_tick)
  );

  // R7
  property no_tick_after_write_p;
    @(posedge clk) disable iff (rst) cfg_we |=> !bit_tick;
  endproperty
  write_quiet_chk: assert property (no_tick_after_write_p);

  // R1
  property cfg_capture_p;
    @(posedge clk) disable iff (rst) cfg_we |=> cfg_q == $past(cfg_wdata);
  endproperty
  cfg_capture_chk: assert property (cfg_capture_p);

  // R6
  property idle_src_quiet_p;
    @(posedge clk) disable iff (rst) (!src_en && !cfg_we) |=> !$rose(u_pdiv.pre_en);
  endproperty
  idle_src_chk: assert property (idle_src_quiet_p);
endmodule

// File: tb/baud_tick_gen_test.sv
module baud_tick_gen_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        xtal_en = 1'b1;
  logic        alt_en = 1'b0;
  logic        alt_toggle = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        bit_tick;

  int total = 0;
  int bad = 0;
  bit wd_hit = 1'b0;

  localparam logic [31:0] FLD  = 32'h0080_0000; // bit 23
  localparam logic [31:0] XTAL = 32'h0100_0000; // bit 24
  localparam logic [31:0] NOPD = 32'h0400_0000; // bit 26
  localparam logic [31:0] PD2  = 32'h0800_0000; // bit 27

  baud_tick_gen uut (
    .clk(clk), .rst(rst), .xtal_en(xtal_en), .alt_en(alt_en),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .bit_tick(bit_tick)
  );

  always #10 clk = ~clk;

  always @(negedge clk) if (alt_toggle) alt_en <= ~alt_en;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called right after the negedge that follows the reference edge
  task automatic measure(output int lat, output int ivl);
    int n = 0;
    int m = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk); n++;
      if (bit_tick) break;
    end
    lat = n;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk); m++;
      if (bit_tick) break;
    end
    ivl = m;
  endtask

  task automatic write_cfg(input logic [31:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(posedge clk);
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic run_case(input string req, input logic [31:0] v, input int lat_e, input int ivl_e);
    int lat, ivl;
    write_cfg(v);
    check({req, " quiet after write"}, int'(bit_tick), 0);
    measure(lat, ivl);
    check({req, " first tick"}, lat, lat_e);
    check({req, " period"}, ivl, ivl_e);
  endtask

  task automatic t_reset();
    int lat, ivl;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    check("R1 tick low after reset", int'(bit_tick), 0);
    measure(lat, ivl);
    check("R1 first tick", lat, 16);
    check("R1 period", ivl, 15);
  endtask

  task automatic t_width();
    write_cfg(FLD | XTAL | 32'd2);
    while (!bit_tick) @(negedge clk);
    @(negedge clk);
    check("R8 tick one cycle", int'(bit_tick), 0);
  endtask

  task automatic t_midcount();
    int lat, ivl;
    write_cfg(FLD | XTAL | 32'd40);
    repeat (17) @(negedge clk);
    run_case("R7 rewrite mid count", FLD | XTAL | NOPD | 32'd3, 5, 4);
  endtask

  task automatic t_alt();
    int seen = 0;
    int lat, ivl;
    alt_en = 1'b0;
    write_cfg(FLD | NOPD | 32'd1);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (bit_tick) seen++;
    end
    check("R6 idle alternate source", seen, 0);
    alt_toggle = 1'b1;
    write_cfg(FLD | NOPD | 32'd3);
    measure(lat, ivl);
    check("R6 gapped source period", ivl, 8);
    alt_toggle = 1'b0;
    alt_en = 1'b1;
    run_case("R6 alternate source", FLD | NOPD | 32'd3, 5, 4);
  endtask

  initial begin
    fork
      begin
        t_reset();
        run_case("R2 R3 div3", FLD | XTAL | 32'd9, 31, 30);
        run_case("R3 no prediv", FLD | XTAL | NOPD | 32'd5, 7, 6);
        run_case("R3 div2", FLD | XTAL | PD2 | 32'd5, 13, 12);
        run_case("R4 both bits", FLD | XTAL | PD2 | NOPD | 32'd5, 13, 12);
        run_case("R5 fixed divisor", XTAL | 32'd2, 25, 24);
        run_case("R9 div0 none", FLD | XTAL | NOPD, 2, 1);
        run_case("R9 div0 div3", FLD | XTAL, 4, 3);
        run_case("R10 spare bits", 32'hF200_0000 | FLD | XTAL | 32'd3, 13, 12);
        t_width();
        t_midcount();
        t_alt();
      end
      begin
        repeat (150000) @(posedge clk);
        wd_hit = 1'b1;
      end
    join_any
    if (wd_hit) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=done");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule